// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

The block derives two periodic time-out ticks from a single input clock. The base tick has a period set by a static option input, from 2^12 to 2^15 clock cycles. The real-time tick has a period chosen by a 3-bit field that software writes, from 2^8 to 2^15 clock cycles. Both ticks come from one free-running 15-bit prescaler. A tick fires when the low bits of the prescaler, up to the selected position, are all ones.

Each tick sets its own request flag and also sets a shared multi-function flag. The shared flag drives one interrupt request toward a CPU, which services it at a fixed vector. The request is raised only while software has enabled it and the CPU reports that its stack has room. Each tick is also output as a one-cycle enable pulse, so that a downstream timer can count ticks and reach longer periods.

Software uses a small write port to set the select field and the enable bit, and to clear flags by writing ones.

Top module: `tick_irq_gen`

## Requirements
- R1: `rt_tick` pulses for exactly one cycle every 2^(8+N) clock cycles, where N is the active 3-bit select value.
- R2: `base_tick` pulses for exactly one cycle every 2^(12+`base_opt`) clock cycles. `base_opt` is treated as static between resets.
- R3: The cycle in which `base_tick` is high, `base_flag` and `mf_flag` are also high.
- R4: The cycle in which `rt_tick` is high, `rt_flag` and `mf_flag` are also high.
- R5: A write with `wr_addr`=1 clears the flags selected by ones in `wr_data`: bit 0 clears the base flag, bit 1 the real-time flag and bit 2 the shared flag. A flag otherwise holds its value. When a tick and a clear of its flag arrive on the same edge, the flag stays set.
- R6: `irq_req` is high exactly when the enable bit is set, `mf_flag` is high and `stack_full` is low. `irq_vec` always reads 8'h18.
- R7: A write with `wr_addr`=0 loads the pending select from `wr_data[2:0]` and the interrupt enable from `wr_data[3]`. A new select becomes active at the next tick of the old select, and from then on ticks fall at prescaler values whose low 8+N bits are all ones.
- R8: `sel_discouraged` is high while the most recently written select value is below 4, which means a divide of 2^8 to 2^11.
- R9: After reset the prescaler is zero, all flags, ticks and the enable bit are zero, and both the pending and the active select are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_opt | input | 2 | Static base period option, divide by 2^(12+value) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control (select, enable), 1 = flag clear |
| wr_data | input | 8 | Write data |
| stack_full | input | 1 | CPU reports its stack is full |
| base_tick | output | 1 | One-cycle base tick enable |
| rt_tick | output | 1 | One-cycle real-time tick enable |
| base_flag | output | 1 | Base request flag |
| rt_flag | output | 1 | Real-time request flag |
| mf_flag | output | 1 | Shared multi-function request flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Service vector address (18h) |
| sel_discouraged | output | 1 | Written select is in the discouraged range |

## Verification
A behavioural model tracks an integer prescaler and is compared with every output on every clock. This is done with real-time selects 0, 1, 2, 5 and 7 and with base options 0 and 3. Running several selects separates a wrong bit position from a wrong handover point. Measuring the exact interval after a change from select 5 to select 1 shows whether the switch waits for the old tick.

Clears are timed to land on the same edge as a predicted tick. This tells set-over-clear priority apart from clear-over-set. Toggling `stack_full` while the enable bit is both off and on separates each gating term of the request.

// File: rtl/tick_irq_gen.sv
module tick_irq_gen #(
  parameter int CNT_W        = 15,
  parameter int SEL_W        = 3,
  parameter int RT_MIN_EXP   = 8,
  parameter int OPT_W        = 2,
  parameter int BASE_MIN_EXP = 12,
  parameter int DISC_LIMIT   = 4,
  parameter int DATA_W       = 8,
  parameter logic [7:0] VECTOR = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPT_W-1:0]  base_opt,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stack_full,
  output logic              base_tick,
  output logic              rt_tick,
  output logic              base_flag,
  output logic              rt_flag,
  output logic              mf_flag,
  output logic              irq_req,
  output logic [7:0]        irq_vec,
  output logic              sel_discouraged
);

  localparam int CLR_BASE = 0;
  localparam int CLR_RT   = 1;
  localparam int CLR_MF   = 2;
  localparam int EN_BIT   = SEL_W;

  logic [CNT_W-1:0] cnt, rt_mask, base_mask;
  logic [SEL_W-1:0] sel_pend, sel_act;
  logic             irq_en, rt_roll, base_roll, wr_ctrl, wr_clr;

  assign rt_mask   = CNT_W'((32'd1 << (RT_MIN_EXP + 32'(sel_act))) - 32'd1);
  assign base_mask = CNT_W'((32'd1 << (BASE_MIN_EXP + 32'(base_opt))) - 32'd1);
  assign rt_roll   = (cnt & rt_mask) == rt_mask;
  assign base_roll = (cnt & base_mask) == base_mask;
  assign wr_ctrl   = wr_en & ~wr_addr;
  assign wr_clr    = wr_en & wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sel_pend  <= '0;
      sel_act   <= '0;
      irq_en    <= 1'b0;
      base_tick <= 1'b0;
      rt_tick   <= 1'b0;
      base_flag <= 1'b0;
      rt_flag   <= 1'b0;
      mf_flag   <= 1'b0;
    end else begin
      cnt       <= cnt + 1'b1;
      base_tick <= base_roll;
      rt_tick   <= rt_roll;
      if (rt_roll) sel_act <= sel_pend;
      if (wr_ctrl) begin
        sel_pend <= wr_data[SEL_W-1:0];
        irq_en   <= wr_data[EN_BIT];
      end
      base_flag <= base_roll | (base_flag & ~(wr_clr & wr_data[CLR_BASE]));
      rt_flag   <= rt_roll   | (rt_flag   & ~(wr_clr & wr_data[CLR_RT]));
      mf_flag   <= base_roll | rt_roll | (mf_flag & ~(wr_clr & wr_data[CLR_MF]));
    end
  end

  assign irq_req         = irq_en & mf_flag & ~stack_full;
  assign irq_vec         = VECTOR;
  assign sel_discouraged = sel_pend < SEL_W'(DISC_LIMIT);

  assert_rt_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rt_tick |=> !rt_tick);
  assert_base_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> !base_tick);
  assert_base_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> (base_flag && mf_flag));
  assert_rt_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rt_tick |-> (rt_flag && mf_flag));
  assert_mf_clear_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mf_flag) |-> $past(wr_en && wr_addr && wr_data[CLR_MF]));
  assert_sel_switch_at_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_act) |-> rt_tick);

endmodule

// File: tb/tick_irq_gen_bench.sv
module tick_irq_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] base_opt = 2'd0;
  logic wr_en = 1'b0, wr_addr = 1'b0, stack_full = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic base_tick, rt_tick, base_flag, rt_flag, mf_flag, irq_req, sel_discouraged;
  logic [7:0] irq_vec;

  tick_irq_gen u_tick_irq_gen (
    .clk(clk), .rst_n(rst_n), .base_opt(base_opt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stack_full(stack_full), .base_tick(base_tick), .rt_tick(rt_tick),
    .base_flag(base_flag), .rt_flag(rt_flag), .mf_flag(mf_flag), .irq_req(irq_req),
    .irq_vec(irq_vec), .sel_discouraged(sel_discouraged));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit compare_on = 1'b0, done = 1'b0;

  int m_cnt = 0, m_act = 0, m_pend = 0, rp, bp;
  bit m_en, m_bt, m_rt, m_bf, m_rf, m_mf, rr, br;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_pend = 0; m_en = 0;
      m_bt = 0; m_rt = 0; m_bf = 0; m_rf = 0; m_mf = 0;
    end else begin
      rp = 1 << (8 + m_act);
      bp = 1 << (12 + int'(base_opt));
      rr = (m_cnt % rp) == rp - 1;
      br = (m_cnt % bp) == bp - 1;
      m_rt = rr; m_bt = br;
      m_bf = br || (m_bf && !(wr_en && wr_addr && wr_data[0]));
      m_rf = rr || (m_rf && !(wr_en && wr_addr && wr_data[1]));
      m_mf = br || rr || (m_mf && !(wr_en && wr_addr && wr_data[2]));
      if (rr) m_act = m_pend;
      if (wr_en && !wr_addr) begin m_pend = int'(wr_data[2:0]); m_en = wr_data[3]; end
      m_cnt = (m_cnt + 1) % 32768;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      chk("R1", "rt_tick", rt_tick, m_rt);
      chk("R2", "base_tick", base_tick, m_bt);
      chk("R3", "base_flag", base_flag, m_bf);
      chk("R4", "rt_flag", rt_flag, m_rf);
      chk("R5", "mf_flag", mf_flag, m_mf);
      chk("R6", "irq_req", irq_req, m_en && m_mf && !stack_full);
      chk("R6", "irq_vec", irq_vec, 8'h18);
      chk("R8", "sel_discouraged", sel_discouraged, m_pend < 4);
    end
    if (cycles > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic write(input bit addr, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic run(input int n, input bit toggle_full);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (toggle_full && (i % 37 == 0)) stack_full = ~stack_full;
      if (i % 301 == 150) begin
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'(1 << ((i / 301) % 3));
      end else begin
        wr_en = 1'b0; wr_data = 8'd0;
      end
    end
    @(negedge clk); wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic collide(input bit use_rt);
    int p;
    forever begin
      @(negedge clk);
      p = use_rt ? (1 << (8 + m_act)) : (1 << (12 + int'(base_opt)));
      if ((m_cnt % p) == p - 1) break;
    end
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h07;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'd0;
    if (use_rt) chk("R5", "rt_flag kept on set/clear collision", rt_flag, 1);
    else        chk("R5", "base_flag kept on set/clear collision", base_flag, 1);
    chk("R5", "mf_flag kept on set/clear collision", mf_flag, 1);
  endtask

  task automatic do_reset(input logic [1:0] opt);
    @(negedge clk); rst_n = 1'b0; base_opt = opt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int gap;
    do_reset(2'd0);
    @(negedge clk);
    // R9: one edge after release the prescaler is 1, so nothing has fired yet
    chk("R9", "flags after reset", {base_flag, rt_flag, mf_flag}, 0);
    chk("R9", "ticks after reset", {base_tick, rt_tick}, 0);
    chk("R9", "irq after reset", irq_req, 0);
    chk("R9", "select 0 after reset marks discouraged", sel_discouraged, 1);
    compare_on = 1'b1;

    write(1'b0, 8'h02);
    run(3000, 1'b1);
    write(1'b0, 8'h0A);
    run(3000, 1'b1);
    collide(1'b1);
    collide(1'b0);
    write(1'b0, 8'h0D);
    run(10000, 1'b0);

    write(1'b0, 8'h09);
    @(negedge clk);
    while (!rt_tick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!rt_tick);
    chk("R7", "interval after switch 5->1", gap, 512);
    chk("R8", "select 1 discouraged", sel_discouraged, 1);

    write(1'b0, 8'h0F);
    run(40000, 1'b1);

    compare_on = 1'b0;
    do_reset(2'd3);
    compare_on = 1'b1;
    write(1'b0, 8'h0E);
    run(36000, 1'b1);
    collide(1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule